// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple on-chip request port and an external 16-bit asynchronous static RAM of 262,144 words. A host presents a word address, write data, two byte enables, a write flag and a request. When the controller shows it is free, it accepts the request. It then plays out the memory's control sequence, with every phase length counted in system clock cycles. Reads return a registered word together with a one-cycle valid strobe. Byte lanes that were not enabled come back as zero.

A write only takes place while chip enable, write enable and at least one byte select are low together. This controller always ends a write by raising the byte selects. Data and address stay driven for one more cycle after that edge. The data bus is split into an output word, an output-enable and an input word, so the pad ring can build the tristate. Output enable is always high while the controller drives the bus. With `BURST_WE` set, write enable and chip enable stay low through the idle cycle after a write. A write accepted in that cycle continues without a write-enable pulse, and the byte selects alone frame each word.

The state machine has seven states:
- `ST_IDLE`: the only state with ready high.
- `ST_RD_ACCESS`: lasts `RD_CYC` cycles.
- `ST_RD_CAPTURE`: one cycle.
- `ST_TURN`: lasts `TA_CYC` cycles.
- `ST_WR_SETUP`: lasts `SU_CYC` cycles.
- `ST_WR_STROBE`: lasts `WS_CYC` cycles.
- `ST_WR_RECOVER`: one cycle.

The transitions are:
- IDLE to RD_ACCESS on an accepted read, and IDLE to WR_SETUP on an accepted write.
- RD_ACCESS to RD_CAPTURE, then to TURN, then back to IDLE.
- WR_SETUP to WR_STROBE, then to WR_RECOVER, then back to IDLE.

All memory pins come from flops.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is applied, mem_ce_n, mem_oe_n and mem_we_n are high, both mem_bsel_n bits are high, mem_dq_oe is low, host_ready is high and host_rvalid is low.
- R2: host_ready is high only in cycles where the controller is idle. A request is accepted on a clock edge where host_req and host_ready are both high. host_ready is low in the cycle after an acceptance.
- R3: For RD_CYC+1 cycles after a read is accepted, the controller holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0. It drives mem_bsel_n to the inverse of host_be (bit 0 is data bits 7:0, bit 1 is bits 15:8) and mem_addr to the latched address.
- R4: The read word is sampled at the end of the last of those cycles. host_rvalid is high for exactly one cycle, RD_CYC+2 cycles after acceptance, with host_rdata holding the sampled word. Lanes whose host_be bit was 0 read as zero.
- R5: After a read, all memory controls are high and mem_dq_oe is low for TA_CYC cycles before host_ready returns.
- R6: For SU_CYC cycles after a write is accepted, the controller holds mem_ce_n=0, mem_we_n=0, mem_oe_n=1 and both byte selects high. It drives mem_dq_oe=1 with the latched data and address.
- R7: For the next WS_CYC cycles, mem_bsel_n equals the inverse of host_be, and address and data stay unchanged while the write strobe is active.
- R8: The write ends by the byte selects rising. For one cycle after that, chip enable and write enable stay low and data stays driven.
- R9: mem_dq_oe is never high while mem_oe_n is low.
- R10: With BURST_WE=1, in the first idle cycle after a write, mem_ce_n and mem_we_n stay low with both byte selects high and mem_dq_oe low. A write accepted in that cycle keeps mem_we_n low without a gap. In later idle cycles both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request valid |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_ready | output | 1 | Controller can accept a request |
| host_rdata | output | 16 | Read word, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle read-data strobe |
| mem_addr | output | 18 | Memory address |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bsel_n | output | 2 | Byte selects, active low, bit 0 = low byte |

## Verification
A wrong state or phase counter shows on the memory pins in the very next cycle. A phase would be stretched or cut, a byte select would come at the wrong time, or host_ready would be raised early. These faults are caught by comparing every control pin against a model in each clock. A wrong capture point or lane mask shows up RD_CYC+2 cycles after the read is accepted, as a wrong host_rdata word. A missed write or one landing on the wrong lane only appears when that word is read back later, so every write pattern is followed by reads through each lane.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_STROBE,
        ST_WR_RECOVER,
        ST_TURN
    } ctrl_state_e;
endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int LANES    = 2,
    parameter int RD_CYC   = 2,
    parameter int SU_CYC   = 1,
    parameter int WS_CYC   = 2,
    parameter int TA_CYC   = 1,
    parameter bit BURST_WE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [LANES-1:0] be,
    output logic             accept,
    output ctrl_state_e      state_q,
    output logic [LANES-1:0] be_q,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] bsel_n,
    output logic             drive_en,
    output logic             ready
);
    localparam int M1    = (RD_CYC > SU_CYC) ? RD_CYC : SU_CYC;
    localparam int M2    = (WS_CYC > TA_CYC) ? WS_CYC : TA_CYC;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] RD_L = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] SU_L = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] WS_L = CNT_W'(WS_CYC - 1);
    localparam logic [CNT_W-1:0] TA_L = CNT_W'(TA_CYC - 1);

    ctrl_state_e      state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LANES-1:0] be_d;
    logic             hold_d;
    logic             last;

    assign accept = req && ready;
    assign last   = (cnt_q == '0);
    assign be_d   = accept ? be : be_q;
    assign hold_d = BURST_WE && (state_q == ST_WR_RECOVER);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                state_d = wr ? ST_WR_SETUP : ST_RD_ACCESS;
                cnt_d   = wr ? SU_L : RD_L;
            end
            ST_RD_ACCESS: if (last) state_d = ST_RD_CAPTURE;
                          else      cnt_d   = cnt_q - 1'b1;
            ST_RD_CAPTURE: begin
                state_d = ST_TURN;
                cnt_d   = TA_L;
            end
            ST_TURN: if (last) state_d = ST_IDLE;
                     else      cnt_d   = cnt_q - 1'b1;
            ST_WR_SETUP: if (last) begin
                state_d = ST_WR_STROBE;
                cnt_d   = WS_L;
            end else cnt_d = cnt_q - 1'b1;
            ST_WR_STROBE: if (last) state_d = ST_WR_RECOVER;
                          else      cnt_d   = cnt_q - 1'b1;
            ST_WR_RECOVER: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            be_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            be_q    <= be_d;
        end
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1;
            bsel_n <= '1; drive_en <= 1'b0; ready <= 1'b1;
        end else begin
            ce_n <= 1'b1; oe_n <= 1'b1; we_n <= 1'b1;
            bsel_n <= '1; drive_en <= 1'b0; ready <= 1'b0;
            unique case (state_d)
                ST_IDLE: begin
                    ready <= 1'b1;
                    ce_n  <= !hold_d;
                    we_n  <= !hold_d;
                end
                ST_RD_ACCESS, ST_RD_CAPTURE: begin
                    ce_n <= 1'b0; oe_n <= 1'b0; bsel_n <= ~be_d;
                end
                ST_WR_SETUP, ST_WR_RECOVER: begin
                    ce_n <= 1'b0; we_n <= 1'b0; drive_en <= 1'b1;
                end
                ST_WR_STROBE: begin
                    ce_n <= 1'b0; we_n <= 1'b0; drive_en <= 1'b1;
                    bsel_n <= ~be_d;
                end
                ST_TURN: ;
                default: ;
            endcase
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> oe_n);
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  ctrl_state_e       state_q,
    input  logic [LANES-1:0]  be_q,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] lane_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr    <= '0;
            mem_dq_out  <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr   <= host_addr;
                mem_dq_out <= host_wdata;
            end
            host_rvalid <= (state_q == ST_RD_CAPTURE);
            if (state_q == ST_RD_CAPTURE)
                host_rdata <= mem_dq_in & lane_mask;
        end
    end

    // R4
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int RD_CYC   = 2,
    parameter int SU_CYC   = 1,
    parameter int WS_CYC   = 2,
    parameter int TA_CYC   = 1,
    parameter bit BURST_WE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic                 host_wr,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    input  logic [DATA_W/8-1:0]  host_be,
    output logic                 host_ready,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_in,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W/8-1:0]  mem_bsel_n
);
    localparam int LANES = DATA_W / 8;

    ctrl_state_e      state_q;
    logic [LANES-1:0] be_q;
    logic             accept;
    logic             strobe;

    sram_ctrl_fsm #(
        .LANES(LANES), .RD_CYC(RD_CYC), .SU_CYC(SU_CYC),
        .WS_CYC(WS_CYC), .TA_CYC(TA_CYC), .BURST_WE(BURST_WE)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr), .be(host_be),
        .accept(accept), .state_q(state_q), .be_q(be_q),
        .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .bsel_n(mem_bsel_n),
        .drive_en(mem_dq_oe), .ready(host_ready)
    );

    sram_ctrl_datapath #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
    ) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .state_q(state_q), .be_q(be_q), .mem_dq_in(mem_dq_in),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    assign strobe = !mem_ce_n && !mem_we_n && !(&mem_bsel_n);

    // R7
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (!strobe || ($stable(mem_addr) && $stable(mem_dq_out))));

    // R8
    write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (strobe || (!mem_ce_n && !mem_we_n && mem_dq_oe)));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/100ps
module sram_lane_ctrl_bench;
    localparam int RD = 2, SU = 1, WS = 2, TA = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [17:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_ready, host_rvalid;
    logic [15:0] host_rdata;
    logic [17:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic        mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [1:0]  mem_bsel_n;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.RD_CYC(RD), .SU_CYC(SU), .WS_CYC(WS), .TA_CYC(TA), .BURST_WE(1'b1))
    u_sram_lane_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n)
    );

    // external memory model (low 8 address bits decoded)
    logic [15:0] mem [0:255];
    logic [15:0] ref_mem [0:255];
    initial for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end

    always_comb begin
        for (int l = 0; l < 2; l++)
            mem_dq_in[l*8 +: 8] = (!mem_ce_n && mem_we_n && !mem_oe_n)
                ? (!mem_bsel_n[l] ? mem[mem_addr[7:0]][l*8 +: 8] : 8'hA5) : 8'h00;
    end

    always @(posedge clk) begin
        if (rst_n && !mem_ce_n && !mem_we_n) begin
            for (int l = 0; l < 2; l++) begin
                if (!mem_bsel_n[l]) begin
                    if (!mem_dq_oe) begin
                        fails++;
                        $display("FAIL R6: strobe on lane %0d without drive, got oe=%b exp 1", l, mem_dq_oe);
                    end
                    mem[mem_addr[7:0]][l*8 +: 8] <= mem_dq_out[l*8 +: 8];
                end
            end
        end
    end

    // cycle-by-cycle expectation queue
    typedef struct {
        logic ce, oe, we; logic [1:0] bs; logic drv, rdy, rv, chk_a, last_wr;
        logic [17:0] a; logic [15:0] d; string tag;
    } exp_t;
    exp_t expq[$];
    bit   held = 0;

    function automatic exp_t mk(logic ce, logic oe, logic we, logic [1:0] bs, logic drv,
                                logic rdy, logic rv, logic chk_a, logic [17:0] a,
                                logic [15:0] d, string tag);
        exp_t e;
        e.ce = ce; e.oe = oe; e.we = we; e.bs = bs; e.drv = drv; e.rdy = rdy;
        e.rv = rv; e.chk_a = chk_a; e.a = a; e.d = d; e.tag = tag; e.last_wr = 0;
        return e;
    endfunction

    task automatic push_seq(bit w, logic [17:0] a, logic [15:0] d, logic [1:0] b);
        exp_t e;
        logic [15:0] m;
        m = {{8{b[1]}}, {8{b[0]}}};
        if (w) begin
            for (int i = 0; i < SU; i++) expq.push_back(mk(0,1,0,2'b11,1,0,0,1,a,d,"R6"));
            for (int i = 0; i < WS; i++) expq.push_back(mk(0,1,0,~b,1,0,0,1,a,d,"R7"));
            e = mk(0,1,0,2'b11,1,0,0,1,a,d,"R8"); e.last_wr = 1; expq.push_back(e);
            ref_mem[a[7:0]] = (ref_mem[a[7:0]] & ~m) | (d & m);
        end else begin
            for (int i = 0; i < RD + 1; i++) expq.push_back(mk(0,0,1,~b,0,0,0,1,a,0,"R3"));
            for (int i = 0; i < TA; i++)
                expq.push_back(mk(1,1,1,2'b11,0,0,(i == 0),0,a,ref_mem[a[7:0]] & m,"R5"));
        end
    endtask

    task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h exp %h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            exp_t e;
            bit   idle;
            if (expq.size() > 0) begin
                e = expq.pop_front(); idle = 0;
            end else begin
                e = held ? mk(0,1,0,2'b11,0,1,0,0,0,0,"R10") : mk(1,1,1,2'b11,0,1,0,0,0,0,"R2");
                held = 0; idle = 1;
            end
            if (e.last_wr) held = 1;
            chk({mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe} == {e.ce, e.oe, e.we, e.bs, e.drv},
                e.tag, {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe},
                {26'd0, e.ce, e.oe, e.we, e.bs, e.drv});
            chk(host_ready == e.rdy, "R2", {31'd0, host_ready}, {31'd0, e.rdy});
            chk(host_rvalid == e.rv, "R4", {31'd0, host_rvalid}, {31'd0, e.rv});
            if (e.rv) chk(host_rdata == e.d, "R4", {16'd0, host_rdata}, {16'd0, e.d});
            if (e.chk_a) chk(mem_addr == e.a, e.tag, {14'd0, mem_addr}, {14'd0, e.a});
            if (e.drv) chk(mem_dq_out == e.d, e.tag, {16'd0, mem_dq_out}, {16'd0, e.d});
            if (idle && host_req) push_seq(host_wr, host_addr, host_wdata, host_be);
        end
    end

    task automatic issue(bit w, logic [17:0] a, logic [15:0] d, logic [1:0] b);
        host_req = 1; host_wr = w; host_addr = a; host_wdata = d; host_be = b;
        forever begin
            @(negedge clk);
            if (host_ready) begin
                @(posedge clk); #1;
                host_req = 0;
                break;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe, host_ready, host_rvalid} == 8'b11111010,
            "R1", {24'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe, host_ready, host_rvalid},
            32'h000000FA);
        @(posedge clk); #1; rst_n = 1;
        repeat (2) @(posedge clk); #1;
        issue(1, 18'h012, 16'hBEEF, 2'b11);
        issue(0, 18'h012, 16'h0000, 2'b11);
        issue(1, 18'h012, 16'h3355, 2'b01);     // low lane only
        issue(0, 18'h012, 16'h0000, 2'b11);     // R4 expect BE55
        issue(0, 18'h012, 16'h0000, 2'b10);     // R4 expect BE00
        issue(0, 18'h012, 16'h0000, 2'b01);     // R4 expect 0055
        repeat (3) @(posedge clk); #1;
        issue(1, 18'h020, 16'h1234, 2'b11);     // R10 back-to-back burst
        issue(1, 18'h021, 16'hABCD, 2'b10);
        issue(1, 18'h022, 16'h6789, 2'b01);
        issue(0, 18'h020, 16'h0000, 2'b11);
        issue(0, 18'h021, 16'h0000, 2'b11);
        issue(0, 18'h022, 16'h0000, 2'b11);
        issue(1, 18'h012, 16'hFFFF, 2'b00);     // no lane selected
        issue(0, 18'h012, 16'h0000, 2'b11);
        repeat (2) @(posedge clk); #1;
        issue(0, 18'h3FF12, 16'h0000, 2'b11);   // high address bits, same model row
        repeat (12) @(posedge clk);
        done = 1;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R2: got %0d pending exp 0", expq.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule